// File: doc/BRIEF.md
# Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that a processor reaches through six byte-wide registers. A byte placed in the transmit holding register is sent on `txd` as a start bit, seven or eight data bits (least significant first), an optional even-parity bit and one or two stop bits. Frames arriving on `rxd` are rebuilt into bytes and placed in a receive holding register. The bit period is set by a divider selection in the mode register and by an 8-bit rate value.

Four status flags show the state of the port: transmit holding empty, receive holding full, receive overrun and transmit complete. Software clears a flag by writing a zero to its bit. The hardware sets flags; it never clears one, except that transmit complete is dropped when a new frame starts. The flags and the control byte are brought out as plain outputs so that an interrupt arbiter can combine them with its enable bits.

Register offsets on `reg_addr`: 0 mode, 1 rate, 2 control, 3 transmit holding, 4 status, 5 receive holding. Offsets 6 and 7 read as zero.

Top module: `sport_top`

## Requirements
- R1: After reset, mode reads 0x00, rate 0xFF, control 0x00, transmit holding 0xFF and status 0x84, and `txd` idles high.
- R2: A transmitted frame is one low start bit, then data bits least significant first (7 when mode bit 6 is 1, otherwise 8), then an even-parity bit over the sent data bits when mode bit 5 is 1, then one high stop bit, plus a second one when mode bit 3 is 1.
- R3: One bit lasts 32 × D × N clocks. D is 1, 4, 16 or 64 for mode bits [1:0] = 0, 1, 2 or 3. N is the rate register, and 0 there counts as 256.
- R4: Control bit 5 enables the transmitter and control bit 4 the receiver. While bit 5 is 0 no frame starts, even with a byte pending. While bit 4 is 0, incoming frames change neither the flags nor the receive holding register.
- R5: Status bit 7 is transmit-empty, bit 6 receive-full, bit 5 overrun and bit 2 transmit-complete, and the other bits read 0. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R6: When the transmitter is enabled, transmit-empty is 0 and no frame is in progress, the holding byte moves into the shifter in the next cycle, transmit-empty returns to 1 and transmit-complete drops to 0.
- R7: Transmit-complete is set when a frame ends while transmit-empty is 1. If another byte is pending when the frame ends, the next frame follows at once and the flag stays 0.
- R8: A received frame that completes while receive-full is 0 is written to the receive holding register (bit 7 reads 0 in 7-bit mode), and receive-full is set.
- R9: A received frame that completes while receive-full is 1 sets overrun and leaves the receive holding register unchanged.
- R10: The receiver checks the start bit half a bit period after the falling edge. A low pulse shorter than that is ignored, and the receiver then goes back to waiting for a start edge.
- R11: The outputs `evt_tx_empty`, `evt_rx_full`, `evt_overrun` and `evt_tx_end` always equal their status bits, and `ctrl_bits` always equals the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| evt_tx_empty | output | 1 | Transmit-empty flag |
| evt_rx_full | output | 1 | Receive-full flag |
| evt_overrun | output | 1 | Overrun flag |
| evt_tx_end | output | 1 | Transmit-complete flag |
| ctrl_bits | output | 8 | Control register contents, for the interrupt arbiter |

## Verification
The hardest situations to reach from the ports are the ones that depend on how two frames overlap in time. Overrun needs a second complete frame to arrive while receive-full is still set. The back-to-back case needs the next byte committed after the shifter has taken the first byte but before that frame ends. The stimulus waits for transmit-empty to return, writes and commits the second byte straight away, and then checks that transmit-complete is still clear when the second byte is loaded. For overrun, two frames are driven on `rxd` with no status write between them, and then the old byte is read back.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_RATE = 3'd1;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_TXH  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_RXH  = 3'd5;

  localparam int M_LEN7  = 6;
  localparam int M_PAR   = 5;
  localparam int M_STOP2 = 3;
  localparam int C_TXEN  = 5;
  localparam int C_RXEN  = 4;
  localparam int S_EMPTY = 7;
  localparam int S_FULL  = 6;
  localparam int S_OVR   = 5;
  localparam int S_TEND  = 2;

  // start + 8 data + parity + 2 stop
  localparam int MAX_BITS = 12;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  typedef struct packed {
    logic len7;
    logic par;
    logic stop2;
  } frame_cfg_t;

  // divider selection 0..3 -> x1, x4, x16, x64 as a shift amount
  function automatic int unsigned div_shift(input logic [1:0] sel);
    return 2 * int'(sel);
  endfunction
endpackage

// File: rtl/sport_bitclk.sv
module sport_bitclk #(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run)
      cnt_d = (cnt_q == '0) ? period - PER_W'(1) : cnt_q - PER_W'(1);
  end

  assign tick = run && !load && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             hold_full,
  input  logic [7:0]       hold_data,
  input  frame_cfg_t       cfg,
  input  logic [PER_W-1:0] bit_per,
  output logic             load,
  output logic             done,
  output logic             txd
);
  logic                busy_q, busy_d;
  logic [MAX_BITS-1:0] sh_q, sh_d, frame;
  logic [3:0]          left_q, left_d, nbits;
  logic                pbit, tick;

  assign load = tx_en && hold_full && !busy_q;
  assign done = tick && (left_q == 4'd1);

  // frame image, LSB goes out first
  always_comb begin
    pbit  = cfg.len7 ? ^hold_data[6:0] : ^hold_data;
    frame = '1;
    frame[0] = 1'b0;
    if (cfg.len7) begin
      frame[7:1] = hold_data[6:0];
      if (cfg.par) frame[8] = pbit;
    end else begin
      frame[8:1] = hold_data;
      if (cfg.par) frame[9] = pbit;
    end
    nbits = 4'd2 + (cfg.len7 ? 4'd7 : 4'd8) + {3'b0, cfg.par} + {3'b0, cfg.stop2};
  end

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      busy_d = 1'b1;
      sh_d   = frame;
      left_d = nbits;
    end else if (tick) begin
      sh_d   = {1'b1, sh_q[MAX_BITS-1:1]};
      left_d = left_q - 4'd1;
      if (left_q == 4'd1) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  sport_bitclk #(.PER_W(PER_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .load     (load),
    .load_val (bit_per - PER_W'(1)),
    .period   (bit_per),
    .tick     (tick)
  );

  assign txd = busy_q ? sh_q[0] : 1'b1;

  // R4: a disabled transmitter never starts a frame
  p_no_start_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy_q) |=> !busy_q);
endmodule

// File: rtl/sport_rx.sv
module sport_rx import sport_pkg::*; #(
  parameter int PER_W       = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rxd,
  input  frame_cfg_t       cfg,
  input  logic [PER_W-1:0] bit_per,
  output logic             done,
  output logic [7:0]       data
);
  localparam int BITS_W = MAX_BITS - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line, prev_q, arm, tick;
  rx_state_e              state_q, state_d;
  logic [3:0]             idx_q, idx_d, last_idx;
  logic [BITS_W-1:0]      bits_q, bits_d;

  assign line     = sync_q[SYNC_STAGES-1];
  assign arm      = rx_en && (state_q == RX_IDLE) && prev_q && !line;
  assign last_idx = (cfg.len7 ? 4'd7 : 4'd8) + {3'b0, cfg.par} + {3'b0, cfg.stop2};

  sport_bitclk #(.PER_W(PER_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q != RX_IDLE),
    .load     (arm),
    .load_val ((bit_per >> 1) - PER_W'(1)),
    .period   (bit_per),
    .tick     (tick)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bits_d  = bits_q;
    done    = 1'b0;
    if (!rx_en) begin
      state_d = RX_IDLE;
    end else begin
      case (state_q)
        RX_IDLE:  if (arm) state_d = RX_START;
        RX_START: if (tick) begin
          if (!line) begin
            state_d = RX_BITS;
            idx_d   = '0;
          end else begin
            state_d = RX_IDLE;
          end
        end
        RX_BITS: if (tick) begin
          bits_d[idx_q] = line;
          if (idx_q == last_idx) begin
            done    = 1'b1;
            state_d = RX_IDLE;
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  assign data = cfg.len7 ? {1'b0, bits_q[6:0]} : bits_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      state_q <= RX_IDLE;
      idx_q   <= '0;
      bits_q  <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], rxd};
      prev_q  <= line;
      state_q <= state_d;
      idx_q   <= idx_d;
      bits_q  <= bits_d;
    end
  end

  // R4: a disabled receiver falls back to idle
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state_q == RX_IDLE));
  // R10: a start bit found high at mid-bit is dropped
  p_false_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && tick && line) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/sport_top.sv
module sport_top import sport_pkg::*; #(
  parameter int BASE_LOG2   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       evt_tx_empty,
  output logic       evt_rx_full,
  output logic       evt_overrun,
  output logic       evt_tx_end,
  output logic [7:0] ctrl_bits
);
  localparam int RATE_W = 8;
  localparam int PER_W  = RATE_W + 1 + BASE_LOG2 + 6;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  logic [7:0] mode_q, mode_d, rate_q, rate_d, ctrl_q, ctrl_d;
  logic [7:0] txh_q, txh_d, rxh_q, rxh_d, clr;
  logic       empty_q, empty_d, full_q, full_d, ovr_q, ovr_d, tend_q, tend_d;
  logic       tx_load, tx_done, rx_done;
  logic [7:0] rx_data;
  logic [PER_W-1:0] rate_ext, bit_per;
  frame_cfg_t cfg;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign cfg      = '{len7: mode_q[M_LEN7], par: mode_q[M_PAR], stop2: mode_q[M_STOP2]};
  assign rate_ext = (rate_q == '0) ? (PER_W'(1) << RATE_W) : PER_W'(rate_q);
  assign bit_per  = rate_ext << (BASE_LOG2 + div_shift(mode_q[1:0]));

  always_comb begin
    mode_d = mode_q;
    rate_d = rate_q;
    ctrl_d = ctrl_q;
    txh_d  = txh_q;
    if (reg_wr) begin
      case (reg_addr)
        A_MODE:  mode_d = reg_wdata;
        A_RATE:  rate_d = reg_wdata;
        A_CTRL:  ctrl_d = reg_wdata;
        A_TXH:   txh_d  = reg_wdata;
        default: ;
      endcase
    end
  end

  // flags: software writes zeros to clear, hardware sets
  always_comb begin
    clr     = (reg_wr && reg_addr == A_STAT) ? ~reg_wdata : 8'h00;
    empty_d = (empty_q & ~clr[S_EMPTY]) | tx_load;
    tend_d  = (tend_q & ~clr[S_TEND] & ~tx_load)
            | (tx_done & empty_q & ~clr[S_EMPTY]);
    full_d  = (full_q & ~clr[S_FULL]) | (rx_done & ~full_q);
    ovr_d   = (ovr_q & ~clr[S_OVR]) | (rx_done & full_q);
    rxh_d   = (rx_done && !full_q) ? rx_data : rxh_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q  <= 8'h00;
      rate_q  <= 8'hFF;
      ctrl_q  <= 8'h00;
      txh_q   <= 8'hFF;
      rxh_q   <= 8'h00;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      tend_q  <= 1'b1;
    end else begin
      mode_q  <= mode_d;
      rate_q  <= rate_d;
      ctrl_q  <= ctrl_d;
      txh_q   <= txh_d;
      rxh_q   <= rxh_d;
      empty_q <= empty_d;
      full_q  <= full_d;
      ovr_q   <= ovr_d;
      tend_q  <= tend_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_RATE:  reg_rdata = rate_q;
      A_CTRL:  reg_rdata = ctrl_q;
      A_TXH:   reg_rdata = txh_q;
      A_STAT:  reg_rdata = {empty_q, full_q, ovr_q, 2'b00, tend_q, 2'b00};
      A_RXH:   reg_rdata = rxh_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  sport_tx #(.PER_W(PER_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tx_en     (ctrl_q[C_TXEN]),
    .hold_full (!empty_q),
    .hold_data (txh_q),
    .cfg       (cfg),
    .bit_per   (bit_per),
    .load      (tx_load),
    .done      (tx_done),
    .txd       (txd)
  );

  sport_rx #(.PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rx_en   (ctrl_q[C_RXEN]),
    .rxd     (rxd),
    .cfg     (cfg),
    .bit_per (bit_per),
    .done    (rx_done),
    .data    (rx_data)
  );

  assign evt_tx_empty = empty_q;
  assign evt_rx_full  = full_q;
  assign evt_overrun  = ovr_q;
  assign evt_tx_end   = tend_q;
  assign ctrl_bits    = ctrl_q;

  p_load_refills_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    tx_load |=> (empty_q && !tend_q));
  p_tend_from_done_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(tend_q) |-> $past(tx_done));
  p_store_on_free_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_done && !full_q) |=> (full_q && rxh_q == $past(rx_data)));
  p_overrun_keeps_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_done && full_q) |=> (ovr_q && $stable(rxh_q)));
endmodule

// File: tb/tb_sport_top.sv
`timescale 1ns/1ps
module tb_sport_top;
  localparam logic [2:0] O_MODE = 3'd0, O_RATE = 3'd1, O_CTRL = 3'd2,
                         O_TXH = 3'd3, O_STAT = 3'd4, O_RXH = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rxd_tb = 1'b1;
  logic       txd;
  logic       evt_tx_empty, evt_rx_full, evt_overrun, evt_tx_end;
  logic [7:0] ctrl_bits;

  int checks = 0, failures = 0;
  int bitper = 32;
  bit cfg_len7 = 0, cfg_par = 0, cfg_stop2 = 0;
  bit mon_on = 0;
  bit finished = 0;
  int low_cnt = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  sport_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd_tb), .txd(txd),
    .evt_tx_empty(evt_tx_empty), .evt_rx_full(evt_rx_full),
    .evt_overrun(evt_overrun), .evt_tx_end(evt_tx_end), .ctrl_bits(ctrl_bits)
  );

  always @(negedge clk) if (txd === 1'b0) low_cnt <= low_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_fmt(input logic [7:0] m, input logic [7:0] r);
    wr(O_MODE, m);
    wr(O_RATE, r);
    cfg_len7 = m[6]; cfg_par = m[5]; cfg_stop2 = m[3];
    bitper = 32 * (1 << (2 * int'(m[1:0]))) * ((r == 0) ? 256 : int'(r));
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(cfg_len7 ? {1'b0, b[6:0]} : b);
    wr(O_TXH, b);
    wr(O_STAT, 8'h7F);
  endtask

  task automatic poll_stat(input logic [7:0] mask, input logic [7:0] val,
                           input int limit, input string req);
    logic [7:0] s;
    int n = 0;
    rd(O_STAT, s);
    while (((s & mask) != val) && n < limit) begin
      rd(O_STAT, s);
      n++;
    end
    chk(req, int'(s & mask), int'(val));
  endtask

  task automatic drive_bit(input logic v);
    rxd_tb = v;
    repeat (bitper) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] b);
    int len = cfg_len7 ? 7 : 8;
    logic p = 1'b0;
    @(negedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < len; i++) begin
      drive_bit(b[i]);
      p ^= b[i];
    end
    if (cfg_par) drive_bit(p);
    drive_bit(1'b1);
    if (cfg_stop2) drive_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic measure_start(output int n);
    n = 0;
    @(negedge txd);
    @(negedge clk);
    while (txd == 1'b0) begin
      n++;
      @(negedge clk);
    end
  endtask

  // monitor: decodes txd and compares against the expected queue
  initial begin
    forever begin
      int len;
      logic [7:0] d;
      logic st, pb, sb1, sb2, perr;
      int exp_v, act_v;
      @(negedge txd);
      if (mon_on) begin
        len = cfg_len7 ? 7 : 8;
        d = '0; pb = 1'b0; sb2 = 1'b1;
        repeat (bitper / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < len; i++) begin
          repeat (bitper) @(negedge clk);
          d[i] = txd;
        end
        if (cfg_par) begin
          repeat (bitper) @(negedge clk);
          pb = txd;
        end
        repeat (bitper) @(negedge clk);
        sb1 = txd;
        if (cfg_stop2) begin
          repeat (bitper) @(negedge clk);
          sb2 = txd;
        end
        perr  = cfg_par ? (pb != ^d) : 1'b0;
        act_v = {st, perr, ~sb1, ~sb2, d};
        exp_v = (exp_q.size() > 0) ? int'({4'b0000, exp_q.pop_front()}) : 'hFFF;
        chk("R2 frame", act_v, exp_v);
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, lc0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(O_MODE, v); chk("R1 mode", v, 8'h00);
    rd(O_RATE, v); chk("R1 rate", v, 8'hFF);
    rd(O_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(O_TXH, v);  chk("R1 txhold", v, 8'hFF);
    rd(O_STAT, v); chk("R1 status", v, 8'h84);
    chk("R1 txd idle", txd, 1);
    chk("R11 flag outputs", {evt_tx_empty, evt_rx_full, evt_overrun, evt_tx_end}, 4'b1001);

    // R5 writing ones has no effect
    wr(O_STAT, 8'hFF);
    rd(O_STAT, v); chk("R5 write ones", v, 8'h84);

    // R4 transmitter disabled: pending byte stays put
    set_fmt(8'h00, 8'h01);
    exp_q.push_back(8'hC3);
    wr(O_TXH, 8'hC3);
    wr(O_STAT, 8'h7F);
    rd(O_STAT, v); chk("R5 clear by zero", v, 8'h04);
    lc0 = low_cnt;
    repeat (200) @(negedge clk);
    chk("R4 no tx while disabled", low_cnt - lc0, 0);
    rd(O_STAT, v); chk("R4 byte still pending", v, 8'h04);

    // R6 enable -> load
    mon_on = 1;
    wr(O_CTRL, 8'h30);
    chk("R11 ctrl output", ctrl_bits, 8'h30);
    rd(O_STAT, v); chk("R6 load refills empty", v, 8'h80);
    poll_stat(8'h04, 8'h04, 2000, "R7 tend after frame");
    chk("R11 tend output", evt_tx_end, 1);

    // R2 other formats
    set_fmt(8'h68, 8'h01);
    send_tx(8'hDA);
    poll_stat(8'h84, 8'h84, 3000, "R2 7-bit frame done");
    set_fmt(8'h20, 8'h01);
    send_tx(8'h3C);
    poll_stat(8'h84, 8'h84, 3000, "R2 parity frame done");

    // R7 back-to-back
    set_fmt(8'h00, 8'h01);
    send_tx(8'h11);
    poll_stat(8'h80, 8'h80, 100, "R6 first byte taken");
    send_tx(8'h22);
    poll_stat(8'h80, 8'h80, 2000, "R7 second byte taken");
    rd(O_STAT, v); chk("R7 tend clear with byte pending", v & 8'h04, 0);
    poll_stat(8'h04, 8'h04, 2000, "R7 tend after last frame");
    repeat (20) @(negedge clk);
    chk("R2 all frames seen", exp_q.size(), 0);

    // R3 bit periods (start-bit width)
    mon_on = 0;
    set_fmt(8'h41, 8'h02);
    wr(O_TXH, 8'hFF); wr(O_STAT, 8'h7F);
    measure_start(n); chk("R3 D=4 N=2", n, 256);
    poll_stat(8'h04, 8'h04, 4000, "R3 frame end");
    set_fmt(8'h43, 8'h01);
    wr(O_TXH, 8'hFF); wr(O_STAT, 8'h7F);
    measure_start(n); chk("R3 D=64 N=1", n, 2048);
    poll_stat(8'h04, 8'h04, 25000, "R3 frame end");
    set_fmt(8'h40, 8'h00);
    wr(O_TXH, 8'hFF); wr(O_STAT, 8'h7F);
    measure_start(n); chk("R3 N=0 is 256", n, 8192);
    poll_stat(8'h04, 8'h04, 80000, "R3 frame end");

    // R8 receive
    set_fmt(8'h00, 8'h01);
    rx_frame(8'h96);
    rd(O_STAT, v); chk("R8 full set", v, 8'hC4);
    rd(O_RXH, v);  chk("R8 data", v, 8'h96);
    chk("R11 full output", evt_rx_full, 1);

    // R9 overrun
    rx_frame(8'h3B);
    rd(O_STAT, v); chk("R9 overrun set", v, 8'hE4);
    rd(O_RXH, v);  chk("R9 data kept", v, 8'h96);
    chk("R11 overrun output", evt_overrun, 1);
    wr(O_STAT, 8'h9F);
    rd(O_STAT, v); chk("R5 clear full and overrun", v, 8'h84);

    // R8 seven-bit with parity and two stops
    set_fmt(8'h68, 8'h01);
    rx_frame(8'hCD);
    rd(O_RXH, v); chk("R8 7-bit data", v, 8'h4D);
    wr(O_STAT, 8'hBF);

    // R10 short glitch
    set_fmt(8'h00, 8'h01);
    @(negedge clk);
    rxd_tb = 1'b0;
    repeat (8) @(negedge clk);
    rxd_tb = 1'b1;
    repeat (400) @(negedge clk);
    rd(O_STAT, v); chk("R10 glitch ignored", v, 8'h84);
    rx_frame(8'h5E);
    rd(O_RXH, v); chk("R10 receive after glitch", v, 8'h5E);
    wr(O_STAT, 8'hBF);

    // R4 receiver disabled
    wr(O_CTRL, 8'h20);
    rx_frame(8'h77);
    rd(O_STAT, v); chk("R4 rx disabled flags", v, 8'h84);
    rd(O_RXH, v);  chk("R4 rx disabled data", v, 8'h5E);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule